// File: doc/BRIEF.md
# Impedance Calibration Command Scheduler

This block sits on the controller side of a DDR3-style memory interface. It decides when impedance calibration commands go out to the device. It then keeps the command bus quiet for as long as the device needs to finish each calibration.

The first command is a single long calibration, issued once an init-start strobe arrives. A periodic tick from a system timer then asks for short calibrations. A host may also ask for a further long calibration at any time once initialization is over.

The wait window after a command depends on the kind of command:

- a long calibration during initialization gets the longest window;
- a long calibration after initialization gets a medium window;
- a short calibration gets the shortest window.

While a window is open the block drives only no-operation codes. It holds back the ordinary command stream, which enters through a request/grant pair. Requests for calibration that arrive during a window are remembered and served once the window closes.

Top module: `zq_cal_sched`

## Requirements
- R1: After reset, `cmd_o` is NOP (code 0), and `busy_o`, `done_o`, `init_done_o` and `fwd_gnt_o` are all low.
- R2: When the block is idle and not yet initialized, a high `init_start` at a clock edge produces a long calibration code (1) on `cmd_o` in the next cycle. `busy_o` is then high for exactly T_INIT cycles, counting from that cycle.
- R3: `done_o` pulses for one cycle, in the first cycle after a window in which `busy_o` is low. `init_done_o` rises in the cycle that ends the first long-calibration window and stays high.
- R4: After initialization, a high `host_zqcl` issues a long calibration code (1) with a window of T_OPER cycles. A `host_zqcl` that arrives before `init_done_o` is set is discarded.
- R5: After initialization, a `period_tick` seen while the block is idle issues a short calibration code (2) in the next cycle, with a window of T_SHORT cycles.
- R6: During a window, every cycle after the one that carries the calibration code shows NOP on `cmd_o`.
- R7: A `period_tick` that arrives during a window, or before initialization, is kept pending. Its short calibration goes out in the cycle that follows the `done_o` pulse, or the first idle cycle after initialization.
- R8: When more than one request is due in the same idle cycle, a long calibration is served before a short calibration, and a short calibration before a forwarded request.
- R9: `fwd_req` is granted (`fwd_gnt_o` high and code 3 on `cmd_o` in the next cycle) only when the block is idle, initialized and has no calibration due. Otherwise `fwd_gnt_o` stays low.
- R10: Once initialized, `init_start` has no effect: `cmd_o` stays NOP and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_start | input | 1 | Starts the initial long calibration |
| period_tick | input | 1 | Periodic request for a short calibration |
| host_zqcl | input | 1 | Host request for a long calibration |
| fwd_req | input | 1 | Ordinary command stream asks for a bus slot |
| cmd_o | output | 2 | Encoded command: 0 NOP, 1 long, 2 short, 3 forwarded |
| fwd_gnt_o | output | 1 | The ordinary command owns the bus this cycle |
| busy_o | output | 1 | A calibration window is open |
| done_o | output | 1 | One-cycle pulse after a window closes |
| init_done_o | output | 1 | The initial long calibration has completed |

## Verification
The scheduler is driven with the following patterns:

- **Init strobe with a waiting forward request and a mid-window host request.** This separates the initialization window from the operational one and shows that early host requests are dropped.
- **A lone periodic tick.** This fixes the length of the short window.
- **A tick that lands inside a running short window.** This shows that a request is held rather than lost, and when it is replayed.
- **Host request, tick and forward request raised together.** This exposes the priority order and the operational long window.
- **A late init strobe.** This confirms that the strobe no longer has any effect.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_LONG = 2'd1,
        CMD_SHRT = 2'd2,
        CMD_FWD  = 2'd3
    } zq_cmd_e;

    localparam int unsigned PEND_LONG = 0;
    localparam int unsigned PEND_SHRT = 1;
    localparam int unsigned PEND_N    = 2;

endpackage

// File: rtl/zq_pend_bank.sv
module zq_pend_bank #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] pend_d, pend_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_comb begin
            pend_d[g] = (pend_q[g] | set_i[g]) & ~clr_i[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/zq_win_timer.sv
module zq_win_timer #(
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          active_o,
    output logic          expire_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          act_d, act_q;

    always_comb begin
        cnt_d = cnt_q;
        act_d = act_q;
        if (load_i) begin
            cnt_d = len_i - CW'(1);
            act_d = 1'b1;
        end else if (act_q) begin
            if (cnt_q == '0) act_d = 1'b0;
            else             cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            act_q <= act_d;
        end
    end

    assign active_o = act_q;
    assign expire_o = act_q && (cnt_q == '0);

endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched
    import zq_sched_pkg::*;
#(
    parameter int unsigned T_INIT  = 512,
    parameter int unsigned T_OPER  = 256,
    parameter int unsigned T_SHORT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_start,
    input  logic       period_tick,
    input  logic       host_zqcl,
    input  logic       fwd_req,
    output logic [1:0] cmd_o,
    output logic       fwd_gnt_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       init_done_o
);

    localparam int unsigned T_MAX0 = (T_INIT > T_OPER) ? T_INIT : T_OPER;
    localparam int unsigned T_MAX  = (T_MAX0 > T_SHORT) ? T_MAX0 : T_SHORT;
    localparam int unsigned CW     = $clog2(T_MAX + 1);

    typedef struct packed {
        zq_cmd_e cmd;
        logic    gnt;
        logic    done;
        logic    init_done;
        logic    win_init;
    } sched_t;

    sched_t st_d, st_q;

    logic              busy, expire;
    logic              ld;
    logic [CW-1:0]     ld_len;
    logic [PEND_N-1:0] pend, pend_set, pend_clr;
    logic              want_long, want_shrt;

    always_comb begin
        pend_set            = '0;
        pend_set[PEND_LONG] = host_zqcl & st_q.init_done;
        pend_set[PEND_SHRT] = period_tick;
        want_long           = pend[PEND_LONG] | (host_zqcl & st_q.init_done);
        want_shrt           = pend[PEND_SHRT] | period_tick;
    end

    always_comb begin
        st_d      = st_q;
        st_d.cmd  = CMD_NOP;
        st_d.gnt  = 1'b0;
        st_d.done = expire;
        ld        = 1'b0;
        ld_len    = '0;
        pend_clr  = '0;
        if (expire && st_q.win_init) begin
            st_d.init_done = 1'b1;
            st_d.win_init  = 1'b0;
        end
        if (!busy) begin
            if (!st_q.init_done) begin
                if (init_start) begin
                    st_d.cmd      = CMD_LONG;
                    st_d.win_init = 1'b1;
                    ld            = 1'b1;
                    ld_len        = CW'(T_INIT);
                end
            end else if (want_long) begin
                st_d.cmd            = CMD_LONG;
                ld                  = 1'b1;
                ld_len              = CW'(T_OPER);
                pend_clr[PEND_LONG] = 1'b1;
            end else if (want_shrt) begin
                st_d.cmd            = CMD_SHRT;
                ld                  = 1'b1;
                ld_len              = CW'(T_SHORT);
                pend_clr[PEND_SHRT] = 1'b1;
            end else if (fwd_req) begin
                st_d.cmd = CMD_FWD;
                st_d.gnt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cmd: CMD_NOP, gnt: 1'b0, done: 1'b0,
                      init_done: 1'b0, win_init: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    zq_pend_bank #(.N(PEND_N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .pend_o (pend)
    );

    zq_win_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ld),
        .len_i    (ld_len),
        .active_o (busy),
        .expire_o (expire)
    );

    assign cmd_o       = st_q.cmd;
    assign fwd_gnt_o   = st_q.gnt;
    assign busy_o      = busy;
    assign done_o      = st_q.done;
    assign init_done_o = st_q.init_done;

endmodule

// File: rtl/zq_cal_sched_chk.sv
module zq_cal_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_o,
    input logic       fwd_gnt_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       init_done_o
);

    AST_CAL_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'd1 || cmd_o == 2'd2) |-> busy_o); // R2

    AST_QUIET_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> cmd_o == 2'd0); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R3

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o); // R3

    AST_INIT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_o) |-> done_o); // R3

    AST_GRANT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_gnt_o |-> (!busy_o && init_done_o && cmd_o == 2'd3)); // R9

endmodule

bind zq_cal_sched zq_cal_sched_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .fwd_gnt_o   (fwd_gnt_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .init_done_o (init_done_o)
);

// File: tb/tb_zq_cal_sched.sv
`timescale 1ns/1ps
module tb_zq_cal_sched;

    localparam int unsigned TI = 20;
    localparam int unsigned TO = 12;
    localparam int unsigned TS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_start = 1'b0;
    logic       period_tick = 1'b0;
    logic       host_zqcl = 1'b0;
    logic       fwd_req = 1'b0;
    logic [1:0] cmd_o;
    logic       fwd_gnt_o, busy_o, done_o, init_done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    zq_cal_sched #(.T_INIT(TI), .T_OPER(TO), .T_SHORT(TS)) dut (
        .clk(clk), .rst_n(rst_n), .init_start(init_start),
        .period_tick(period_tick), .host_zqcl(host_zqcl), .fwd_req(fwd_req),
        .cmd_o(cmd_o), .fwd_gnt_o(fwd_gnt_o), .busy_o(busy_o),
        .done_o(done_o), .init_done_o(init_done_o)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Entered one cycle into a window, with 'start' window cycles already seen.
    task automatic wait_window(string req, int start, int exp_len);
        int n = start;
        step();
        while (busy_o && n < 1000) begin
            n++;
            check("R6", "cmd inside window", cmd_o, 0);
            step();
        end
        check(req, "window length", n, exp_len);
        check("R3", "done pulse", done_o, 1);
        check("R6", "cmd at done", cmd_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        fwd_req = 1'b1;
        step(); step();
        rst_n = 1'b1;
        check("R1", "cmd", cmd_o, 0);
        check("R1", "busy", busy_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "init_done", init_done_o, 0);
        step();
        check("R9", "no grant before init", fwd_gnt_o, 0);
    endtask

    task automatic t_init();
        int n = 1;
        init_start = 1'b1;
        step();
        init_start = 1'b0;
        check("R2", "long cmd issued", cmd_o, 1);
        check("R2", "busy at issue", busy_o, 1);
        check("R9", "grant blocked", fwd_gnt_o, 0);
        step();
        while (busy_o && n < 1000) begin
            n++;
            if (n == 4) host_zqcl = 1'b1;
            else        host_zqcl = 1'b0;
            check("R9", "grant blocked in window", fwd_gnt_o, 0);
            step();
        end
        host_zqcl = 1'b0;
        check("R2", "init window length", n, TI);
        check("R3", "done after init", done_o, 1);
        check("R3", "init_done set", init_done_o, 1);
        step();
        check("R4", "early host req dropped", cmd_o, 3);
        check("R9", "grant when idle", fwd_gnt_o, 1);
        fwd_req = 1'b0;
        step();
    endtask

    task automatic t_tick();
        period_tick = 1'b1;
        step();
        period_tick = 1'b0;
        check("R5", "short cmd issued", cmd_o, 2);
        wait_window("R5", 1, TS);
        check("R3", "init_done sticky", init_done_o, 1);
        step();
        check("R5", "no extra cmd", cmd_o, 0);
        check("R3", "done single cycle", done_o, 0);
    endtask

    task automatic t_pending();
        period_tick = 1'b1;
        step();
        period_tick = 1'b0;
        check("R5", "short cmd issued", cmd_o, 2);
        step();
        period_tick = 1'b1;
        step();
        period_tick = 1'b0;
        wait_window("R5", 3, TS);
        step();
        check("R7", "pending tick served", cmd_o, 2);
        wait_window("R7", 1, TS);
        step();
        check("R7", "pending cleared", cmd_o, 0);
    endtask

    task automatic t_priority();
        host_zqcl = 1'b1;
        period_tick = 1'b1;
        fwd_req = 1'b1;
        step();
        host_zqcl = 1'b0;
        period_tick = 1'b0;
        check("R8", "long first", cmd_o, 1);
        check("R8", "no grant", fwd_gnt_o, 0);
        wait_window("R4", 1, TO);
        step();
        check("R8", "short second", cmd_o, 2);
        wait_window("R5", 1, TS);
        step();
        check("R8", "forward last", cmd_o, 3);
        check("R9", "grant after cals", fwd_gnt_o, 1);
        fwd_req = 1'b0;
        step();
        check("R9", "grant drops", fwd_gnt_o, 0);
    endtask

    task automatic t_late_init();
        init_start = 1'b1;
        step();
        init_start = 1'b0;
        check("R10", "cmd stays NOP", cmd_o, 0);
        check("R10", "busy stays low", busy_o, 0);
        step();
        check("R10", "still idle", busy_o, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_init();
        t_tick();
        t_pending();
        t_priority();
        t_late_init();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule